// File: doc/BRIEF.md
# Processor Reset and Exception-Entry Controller

This block steers a processor core into its reset state and into exception handlers. While the reset input is held low, it holds the vector base, status, event and program-counter outputs in their reset values. The level of the bus-request pin on each reset-low clock chooses between a power-on reset and a manual reset. When reset is released, the block issues one branch to the fixed reset address.

Once the core is running, the pipeline sends a one-cycle exception request. The request carries a 12-bit event code and a flag that marks a TLB-miss trap. The block records the code, sets the register-bank bit of the status word and branches to the vector base plus an offset. The offset is larger for TLB-miss traps than for every other event. The pipeline can load a new vector base through a load strobe.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low and `bus_req_i` high sets `expevt_o` to 0x000, which marks a power-on reset.
- R2: A clock edge with `rst_n` low and `bus_req_i` low sets `expevt_o` to 0x020, which marks a manual reset.
- R3: After any clock edge with `rst_n` low, the outputs take their reset values: `vbr_o` is 0, `pc_o` is 0xA0000000 and `branch_valid_o` is 0. `sr_o` is 0x700000F0, where bit 30 is mode, bit 29 is register bank, bit 28 is block, bits 7:4 are the interrupt mask and every other bit is 0.
- R4: On the first clock edge with `rst_n` high after a reset, `branch_valid_o` goes to 1 with `pc_o` at 0xA0000000. `expevt_o` then keeps the code chosen by `bus_req_i` on the last reset-low edge. Later changes of `bus_req_i` have no effect.
- R5: An accepted request raises `branch_valid_o` on the next edge. On that edge `expevt_o` becomes the 12-bit code with bits 31:12 at zero, and `sr_o` bit 29 is set with all other status bits unchanged.
- R6: For an accepted request with `exc_tlb_miss_i` high, `pc_o` becomes the vector base plus 0x400, modulo 2^32.
- R7: For an accepted request with `exc_tlb_miss_i` low, `pc_o` becomes the vector base plus 0x100, modulo 2^32.
- R8: A request is ignored in two cycles: while `branch_valid_o` is 1, and in the first cycle with `rst_n` high. An ignored request changes neither `pc_o` nor `expevt_o`, and raises no branch.
- R9: With `rst_n` high, `vbr_ld_i` loads `vbr_val_i` into `vbr_o` on the next edge. A request accepted in the same cycle uses the old vector base.
- R10: `branch_valid_o` is never high on two edges in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Processor reset, active low, sampled on the clock |
| bus_req_i | input | 1 | Bus-request pin level, selects the reset type |
| exc_req_i | input | 1 | One-cycle exception request |
| exc_tlb_miss_i | input | 1 | The request is a TLB-miss trap |
| exc_code_i | input | 12 | Event code of the request |
| vbr_ld_i | input | 1 | Load strobe for the vector base |
| vbr_val_i | input | 32 | New vector base value |
| vbr_o | output | 32 | Vector base register |
| sr_o | output | 32 | Status register |
| expevt_o | output | 32 | Exception-event register |
| pc_o | output | 32 | Branch target |
| branch_valid_o | output | 1 | One-cycle pulse: branch to `pc_o` |

## Verification
Every result appears exactly one edge after the stimulus that causes it. This covers the reset values after a reset-low edge, the reset branch after the release edge, the handler branch after an accepted request, and the vector base after a load strobe. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so each check reads the value that edge produced. For ignored requests, the request is held high through the pulse cycle, and the check on the following edge confirms that no second branch appears and that the outputs stay unchanged.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 12;

  // status word bit positions
  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;
  localparam int SR_IM_LO  = 4;
  localparam int SR_IM_W   = 4;

  localparam logic [XLEN-1:0] RESET_PC    = 32'hA000_0000;
  localparam logic [XLEN-1:0] OFF_TLB     = 32'h0000_0400;
  localparam logic [XLEN-1:0] OFF_GENERAL = 32'h0000_0100;
  localparam logic [CODE_W-1:0] CODE_POWER  = 12'h000;
  localparam logic [CODE_W-1:0] CODE_MANUAL = 12'h020;

  function automatic logic [XLEN-1:0] sr_reset_value();
    logic [XLEN-1:0] s;
    s = '0;
    s[SR_MD_BIT] = 1'b1;
    s[SR_RB_BIT] = 1'b1;
    s[SR_BL_BIT] = 1'b1;
    s[SR_IM_LO +: SR_IM_W] = '1;
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] reset_code(input logic bus_req);
    return bus_req ? CODE_POWER : CODE_MANUAL;
  endfunction

  function automatic logic [XLEN-1:0] handler_addr(input logic [XLEN-1:0] base,
                                                   input logic tlb_miss);
    return base + (tlb_miss ? OFF_TLB : OFF_GENERAL);
  endfunction
endpackage

// File: rtl/exc_entry_seq.sv
module exc_entry_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic exc_req_i,
  input  logic branch_valid_i,
  output logic rel_pulse_o,
  output logic exc_take_o
);
  logic pend_q;

  // a reset branch is pending from every reset-low edge until the release edge
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b1;
    else        pend_q <= 1'b0;
  end

  assign rel_pulse_o = rst_n && pend_q;
  assign exc_take_o  = rst_n && !pend_q && exc_req_i && !branch_valid_i;

  // R8: the release cycle and a pulse cycle never accept a request
  a_r8_no_take_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse_o |-> !exc_take_o);
endmodule

// File: rtl/exc_entry_vec.sv
module exc_entry_vec
  import exc_entry_pkg::*;
(
  input  logic [XLEN-1:0] vbr_i,
  input  logic            tlb_miss_i,
  output logic [XLEN-1:0] handler_o
);
  assign handler_o = handler_addr(vbr_i, tlb_miss_i);
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_i,
  input  logic              rel_pulse_i,
  input  logic              exc_take_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   handler_i,
  input  logic              vbr_ld_i,
  input  logic [XLEN-1:0]   vbr_val_i,
  output logic [XLEN-1:0]   vbr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   expevt_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              branch_valid_o
);
  localparam int PAD_W = XLEN - CODE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbr_o          <= '0;
      sr_o           <= sr_reset_value();
      expevt_o       <= {{PAD_W{1'b0}}, reset_code(bus_req_i)};
      pc_o           <= RESET_PC;
      branch_valid_o <= 1'b0;
    end else begin
      branch_valid_o <= rel_pulse_i || exc_take_i;
      if (vbr_ld_i) vbr_o <= vbr_val_i;
      if (rel_pulse_i) begin
        pc_o <= RESET_PC;
      end else if (exc_take_i) begin
        pc_o            <= handler_i;
        expevt_o        <= {{PAD_W{1'b0}}, exc_code_i};
        sr_o[SR_RB_BIT] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_i,
  input  logic              exc_req_i,
  input  logic              exc_tlb_miss_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              vbr_ld_i,
  input  logic [XLEN-1:0]   vbr_val_i,
  output logic [XLEN-1:0]   vbr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   expevt_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              branch_valid_o
);
  logic            rel_pulse;
  logic            exc_take;
  logic [XLEN-1:0] handler;

  exc_entry_seq u_seq (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i),
    .branch_valid_i(branch_valid_o),
    .rel_pulse_o(rel_pulse), .exc_take_o(exc_take)
  );

  exc_entry_vec u_vec (
    .vbr_i(vbr_o), .tlb_miss_i(exc_tlb_miss_i), .handler_o(handler)
  );

  exc_entry_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i),
    .rel_pulse_i(rel_pulse), .exc_take_i(exc_take),
    .exc_code_i(exc_code_i), .handler_i(handler),
    .vbr_ld_i(vbr_ld_i), .vbr_val_i(vbr_val_i),
    .vbr_o(vbr_o), .sr_o(sr_o), .expevt_o(expevt_o), .pc_o(pc_o),
    .branch_valid_o(branch_valid_o)
  );

  // R3: a reset-low edge leaves the reset values
  a_r3_reset_state: assert property (@(posedge clk)
    !rst_n |=> (pc_o == RESET_PC && vbr_o == '0 && !branch_valid_o
                && sr_o == 32'h7000_00F0));

  // R4: the release edge produces the reset branch
  a_r4_release_branch: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> (branch_valid_o && pc_o == RESET_PC));

  // R5: an accepted request sets the bank bit and raises the branch
  a_r5_rb_set: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (branch_valid_o && sr_o[SR_RB_BIT]
                  && expevt_o == {20'h0, $past(exc_code_i)}));

  // R6: TLB-miss handler offset
  a_r6_tlb_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_tlb_miss_i) |=> (pc_o == $past(vbr_o) + 32'h400));

  // R7: general handler offset
  a_r7_gen_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exc_tlb_miss_i) |=> (pc_o == $past(vbr_o) + 32'h100));

  // R8: a request during a pulse leaves the event register alone
  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && branch_valid_o) |=> ($stable(expevt_o) && $stable(pc_o)));

  // R9: vector base load
  a_r9_vbr_load: assert property (@(posedge clk) disable iff (!rst_n)
    vbr_ld_i |=> (vbr_o == $past(vbr_val_i)));

  // R10: single-cycle branch pulse
  a_r10_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    branch_valid_o |=> !branch_valid_o);
endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req_i = 1'b1;
  logic        exc_req_i = 1'b0;
  logic        exc_tlb_miss_i = 1'b0;
  logic [11:0] exc_code_i = '0;
  logic        vbr_ld_i = 1'b0;
  logic [31:0] vbr_val_i = '0;
  logic [31:0] vbr_o, sr_o, expevt_o, pc_o;
  logic        branch_valid_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] cur_vbr = '0;

  always #4 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i), .exc_req_i(exc_req_i),
    .exc_tlb_miss_i(exc_tlb_miss_i), .exc_code_i(exc_code_i),
    .vbr_ld_i(vbr_ld_i), .vbr_val_i(vbr_val_i),
    .vbr_o(vbr_o), .sr_o(sr_o), .expevt_o(expevt_o), .pc_o(pc_o),
    .branch_valid_o(branch_valid_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic load_vbr(input logic [31:0] v);
    @(negedge clk);
    vbr_ld_i = 1'b1; vbr_val_i = v;
    edge_sample();
    chk("R9 vbr load", vbr_o, v);
    cur_vbr = v;
    @(negedge clk);
    vbr_ld_i = 1'b0;
  endtask

  task automatic run_exc(input logic [11:0] code, input logic tlb);
    logic [31:0] off;
    logic [31:0] want_pc;
    off = 32'h100 << (tlb ? 2 : 0);
    want_pc = cur_vbr + off;
    @(negedge clk);
    exc_req_i = 1'b1; exc_code_i = code; exc_tlb_miss_i = tlb;
    edge_sample();
    chk("R5 branch valid", {31'b0, branch_valid_o}, 32'd1);
    chk(tlb ? "R6 tlb handler" : "R7 general handler", pc_o, want_pc);
    chk("R5 event code", expevt_o, {20'b0, code});
    chk("R5 status", sr_o, 32'h7000_00F0);
    @(negedge clk);
    exc_code_i = ~code; exc_tlb_miss_i = ~tlb;  // request held in pulse cycle
    edge_sample();
    chk("R10 pulse drops", {31'b0, branch_valid_o}, 32'd0);
    chk("R8 code kept", expevt_o, {20'b0, code});
    chk("R8 pc kept", pc_o, want_pc);
    @(negedge clk);
    exc_req_i = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] vbrs [5];
    vbrs[0] = 32'h0000_0000; vbrs[1] = 32'h8000_0000; vbrs[2] = 32'hFFFF_FF80;
    vbrs[3] = 32'h1234_5678; vbrs[4] = 32'hFFFF_FC00;

    // reset, power-on selection
    repeat (3) edge_sample();
    chk("R3 vbr", vbr_o, 32'h0);
    chk("R3 pc", pc_o, 32'hA000_0000);
    chk("R3 sr", sr_o, 32'h7000_00F0);
    chk("R3 no branch", {31'b0, branch_valid_o}, 32'd0);
    chk("R1 power-on code", expevt_o, 32'h000);
    @(negedge clk); bus_req_i = 1'b0;
    edge_sample();
    chk("R2 manual code", expevt_o, 32'h020);

    // release with a request present and bus_req moving
    @(negedge clk);
    rst_n = 1'b1; bus_req_i = 1'b1;
    exc_req_i = 1'b1; exc_code_i = 12'h5A5; exc_tlb_miss_i = 1'b1;
    edge_sample();
    chk("R4 release branch", {31'b0, branch_valid_o}, 32'd1);
    chk("R4 release pc", pc_o, 32'hA000_0000);
    chk("R4 final reset code", expevt_o, 32'h020);
    edge_sample();
    chk("R10 after release", {31'b0, branch_valid_o}, 32'd0);
    chk("R8 release request ignored", expevt_o, 32'h020);
    chk("R8 release pc kept", pc_o, 32'hA000_0000);
    @(negedge clk); exc_req_i = 1'b0;
    edge_sample();
    chk("R4 bus_req ignored when running", expevt_o, 32'h020);

    // sweep of vector bases, codes and both offsets
    for (int v = 0; v < 5; v++) begin
      load_vbr(vbrs[v]);
      for (int c = 0; c < 4096; c += 117) begin
        run_exc(c[11:0], 1'b0);
        run_exc(c[11:0], 1'b1);
      end
      run_exc(12'hFFF, 1'b1);
      run_exc(12'hFFF, 1'b0);
    end

    // load and request in the same cycle use the old base
    load_vbr(32'h0000_4000);
    @(negedge clk);
    vbr_ld_i = 1'b1; vbr_val_i = 32'h0009_0000;
    exc_req_i = 1'b1; exc_code_i = 12'h1C0; exc_tlb_miss_i = 1'b0;
    edge_sample();
    chk("R9 old base used", pc_o, 32'h0000_4100);
    chk("R9 new base loaded", vbr_o, 32'h0009_0000);
    @(negedge clk); vbr_ld_i = 1'b0; exc_req_i = 1'b0;
    edge_sample();

    // second reset ending with bus_req high
    @(negedge clk); rst_n = 1'b0; bus_req_i = 1'b0;
    edge_sample();
    chk("R2 manual again", expevt_o, 32'h020);
    chk("R3 vbr cleared", vbr_o, 32'h0);
    @(negedge clk); bus_req_i = 1'b1;
    edge_sample();
    chk("R1 power-on again", expevt_o, 32'h000);
    @(negedge clk); rst_n = 1'b1; bus_req_i = 1'b0;
    edge_sample();
    chk("R4 release code", expevt_o, 32'h000);
    chk("R4 release pulse", {31'b0, branch_valid_o}, 32'd1);
    chk("R4 release pc 2", pc_o, 32'hA000_0000);
    edge_sample();
    chk("R10 single pulse", {31'b0, branch_valid_o}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1;
    $finish;
  end
endmodule